// File: doc/BRIEF.md
# Port change interrupt generator

This block watches a set of already-synchronised port pins and raises an interrupt request whenever the pins no longer match a stored reference copy. The request is level based: it stays raised as long as any pin differs from the reference, in either direction. It drops by itself when the pins go back to the reference value. The flag `irq_active` means the shared open-drain interrupt line should be pulled low.

The reference copy is refreshed from the pins whenever the host touches the port through the serial slave. A read refreshes it on the first cycle of the read strobe. A write refreshes it on the first cycle after the write strobe ends. Each refresh clears the request, and any later change is detected again. After reset the reference is all ones, so a pin that is held low raises the request straight away.

Top module: `port_change_irq`

## Requirements
- R1: While `rst_n` is low, `irq_active` is 0 and the reference is all ones. On the first clock edge after reset, `irq_active` becomes 1 if any pin is 0.
- R2: When `pins` differ from the reference in any bit, whether 0→1 or 1→0, `irq_active` is 1 after the next clock edge. It stays 1 while the mismatch lasts and no refresh occurs.
- R3: When the pins return to the reference value with no bus access, `irq_active` returns to 0 after the next clock edge.
- R4: In a cycle where `rd_stb` is 1 and was 0 in the previous cycle, the reference is loaded from `pins`. `irq_active` is 0 after that edge.
- R5: In the first cycle where `wr_stb` is 0 after being 1, the reference is loaded from `pins`. `irq_active` is 0 after that edge. While `wr_stb` stays high, `irq_active` keeps following the comparison.
- R6: A pin value that changes in the same cycle as a refresh is taken into the reference and raises no request. A change in any later cycle is detected again.
- R7: Holding `rd_stb` high beyond its first cycle causes no further refresh.
- R8: A read start and a write end in the same cycle cause a single refresh from the current pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | WIDTH | Synchronised port pin values |
| rd_stb | input | 1 | High during a host read of the port |
| wr_stb | input | 1 | High during a host write to the port |
| irq_active | output | 1 | 1 = interrupt line pulled low |

## Verification
Two functions can land on the same clock edge: a refresh, and a pin change that would raise the request. The bench provokes this by changing the pins in the very cycle `rd_stb` rises. It judges the result by checking that `irq_active` stays 0 both on that edge and on the next one, and then that a later change raises it. The same approach covers a read start and a write end arriving together with new pin values. The expected outcome there is a single refresh and a quiet output.

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  input  logic             rd_stb,
  input  logic             wr_stb,
  output logic             irq_active
);

  logic [WIDTH-1:0] snap;
  logic             rd_q, wr_q, irq_q;

  wire rd_start = rd_stb & ~rd_q;
  wire wr_end   = wr_q & ~wr_stb;
  wire reload   = rd_start | wr_end;
  wire differ   = |(pins ^ snap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap  <= '1;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_stb;
      wr_q  <= wr_stb;
      irq_q <= differ & ~reload;
      if (reload) snap <= pins;
    end
  end

  assign irq_active = irq_q;

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_q) |=> !irq_active);

  assert_write_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_stb) |=> !irq_active);

  assert_mismatch_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && $stable(pins) && !rd_stb && !wr_q) |=> irq_active);

  assert_reload_absorbs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reload) && $stable(pins) && !reload) |=> !irq_active);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_active && snap == '1));

endmodule

// File: tb/sim_port_change_irq.sv
module sim_port_change_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic       irq_active;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  port_change_irq #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pins(pins),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .irq_active(irq_active)
  );

  // {pins, rd_stb, wr_stb, expected irq_active after the following edge}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {8'hFF, 1'b0, 1'b0, 1'b0},  // R1 idle match
    {8'hFE, 1'b0, 1'b0, 1'b1},  // R2 falling bit
    {8'hFF, 1'b0, 1'b0, 1'b0},  // R3 return to reference
    {8'h7F, 1'b0, 1'b0, 1'b1},  // R2
    {8'h7F, 1'b1, 1'b0, 1'b0},  // R4 read start reload
    {8'h7F, 1'b1, 1'b0, 1'b0},  // R7 held
    {8'h77, 1'b1, 1'b0, 1'b1},  // R7 no second reload
    {8'h77, 1'b0, 1'b0, 1'b1},  // R2 persists
    {8'h77, 1'b0, 1'b1, 1'b1},  // R5 during write
    {8'h77, 1'b0, 1'b1, 1'b1},  // R5 during write
    {8'h77, 1'b0, 1'b0, 1'b0},  // R5 write end reload
    {8'h77, 1'b0, 1'b0, 1'b0},  // R5
    {8'hF7, 1'b0, 1'b0, 1'b1},  // R2 rising bit
    {8'h33, 1'b1, 1'b0, 1'b0},  // R6 change at reload
    {8'h33, 1'b0, 1'b0, 1'b0},  // R6 absorbed
    {8'h00, 1'b0, 1'b1, 1'b1},  // R5 write begins, mismatch
    {8'h00, 1'b1, 1'b0, 1'b0},  // R8 read start + write end
    {8'h00, 1'b0, 1'b0, 1'b0},  // R8 single reload
    {8'h01, 1'b0, 1'b0, 1'b1}   // R6 later change detected
  };

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (irq_active !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_active=%b expected %b", req, irq_active, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
          pins   = VEC[i][10:3];
          rd_stb = VEC[i][2];
          wr_stb = VEC[i][1];
          @(negedge clk);
          check(VEC[i][0], $sformatf("vector %0d", i));
        end
        rd_stb = 1'b0; wr_stb = 1'b0;
        rst_n = 1'b0; pins = 8'h00;
        @(negedge clk);
        check(1'b0, "R1 reset with low pins");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, "R1 low pin after reset");
        pins = 8'hFF;
        @(negedge clk);
        check(1'b0, "R3 all ones matches reset reference");
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule